// File: doc/BRIEF.md
# Backpropagation Training Array with Broadcast Bus

This block trains a small two-layer feed-forward network on chip. Six fixed-point neurons work in parallel: four hidden neurons and two output neurons by default. A central sequencer drives one shared broadcast bus. On each bus cycle one source value reaches every neuron of the layer that consumes it.

A training pass starts when `start` is sampled high while the block is idle. The sequencer then runs a fixed order of phases. In the forward phase, the pattern inputs and then the hidden outputs are sent over the bus. In the backward phase, the output-layer error terms are sent back over the same bus, each together with the weight row of the neuron that drives it. In the final phase, every neuron updates its own weights in parallel, one weight index per cycle.

The training patterns and targets come from the pattern index, so the controlling logic only selects which pattern each pass trains on. At the end of a pass the output activations and output error terms stay visible on the ports.

Top module: `bpn_array`

## Requirements
- R1: After reset, `busy` and `done` are 0, and every field of `y_out` and `err_out` is 0.
- R2: A `start` sampled high while `busy` is 0 captures `pat_idx` and begins a pass. `busy` is 1 from the next cycle up to and including the `done` cycle.
- R3: `done` is a one-cycle pulse. It is high 16 clock edges after the edge that sampled `start`. The general count is NUM_IN + N_HID + N_OUT + MAX_FAN + 4.
- R4: A `start` sampled while `busy` is 1 is ignored. No second pass runs, and `busy` is 0 once the current pass has ended.
- R5: Pattern p drives input j with 4096 (1.0) when bit j of p is set, and with 0 otherwise. Output k has target 3686 (0.9) when popcount(p)+k is odd, and 410 (0.1) otherwise.
- R6: Values are signed Q4.12. A net value is the sum of 32-bit products of bus values and weights, taken as arsh(sum,12) and saturated to 16 bits. Hidden neurons take the inputs from the bus, and output neurons take the hidden outputs from the bus, in index order.
- R7: The activation uses a = |arsh(net,8)|. The value g is 4096 if a>=80, 8a+3456 if a>=38, 32a+2560 if a>=16, and 64a+2048 otherwise. The output is g for net>=0 and 4096-g for net<0, so every output lies in [0,4096].
- R8: The slope of the activation is d(O) = narrow(O*(4096-O)), where narrow(x) = sat16(arsh(x,12)). The output error term is narrow(d(O)*sat16(T-O)).
- R9: The hidden error term of neuron i is narrow(d(O_i)*narrow(sum over k of E_k*W_ki)). It uses the output error terms E_k sent over the bus and the weights from before the update.
- R10: Each weight becomes sat16(W + narrow(narrow(X*E)*LR)), with LR = 4096 by default. X is the value that weight received in the forward phase, and E is the neuron's own error term.
- R11: Reset weights are ((5i+3j)%9-4)*512 for hidden neuron i, input j. They are ((5k+3j+7)%9-4)*512 for output neuron k, hidden j.
- R12: `y_out` holds output k in bits [16k+15:16k], and `err_out` uses the same layout. Both keep their values while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training pass |
| pat_idx | input | $clog2(NUM_PAT) | Training pattern selected at start |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| y_out | output | 16*N_OUT | Output-layer activations, Q4.12 |
| err_out | output | 16*N_OUT | Output-layer error terms, Q4.12 |

## Verification
The bench trains all four patterns in turn. Pattern 0 has all inputs at zero, so only the slope and target terms of the output layer come into play. The patterns with one input or two inputs set exercise different hidden weight columns. Repeating pattern 3 back to back shows that both the hidden and the output weight updates reach the next forward result. A start pulse during a pass, and idle gaps after each pass, show that the pass count and the held outputs are not disturbed.

// File: rtl/bpn_pkg.sv
package bpn_pkg;
    localparam int DW     = 16;
    localparam int AW     = 32;
    localparam int FRAC   = 12;
    localparam int ONE    = 1 << FRAC;
    localparam int STEP_W = 8;
    localparam int T_HI   = 3686;
    localparam int T_LO   = 410;
    localparam int WSCALE = 512;

    localparam int KNEE_TOP = 80;
    localparam int KNEE_MID = 38;
    localparam int KNEE_LOW = 16;

    typedef logic signed [DW-1:0] fx_t;
    typedef logic signed [AW-1:0] acc_t;

    typedef enum logic [3:0] {
        PH_IDLE, PH_FWD_IN, PH_ACT_HID, PH_FWD_HID, PH_ACT_OUT,
        PH_ERR_OUT, PH_BACK, PH_ERR_HID, PH_UPD, PH_DONE
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [STEP_W-1:0] step;
    } seq_ctl_t;

    function automatic acc_t fx_mul(fx_t a, fx_t b);
        acc_t x;
        acc_t y;
        x = acc_t'(a);
        y = acc_t'(b);
        return x * y;
    endfunction

    function automatic fx_t sat16(acc_t v);
        if (v > acc_t'(32767))
            return fx_t'(32767);
        else if (v < -acc_t'(32768))
            return fx_t'(-32768);
        else
            return v[DW-1:0];
    endfunction

    function automatic fx_t narrow(acc_t v);
        return sat16(v >>> FRAC);
    endfunction

    function automatic fx_t act_lut(logic [7:0] k);
        int a;
        int y;
        a = k[7] ? int'(k) - 128 : 128 - int'(k);
        if (a >= KNEE_TOP)      y = ONE;
        else if (a >= KNEE_MID) y = a * 8 + 3456;
        else if (a >= KNEE_LOW) y = a * 32 + 2560;
        else                    y = a * 64 + 2048;
        if (!k[7]) y = ONE - y;
        return fx_t'(y);
    endfunction

    function automatic fx_t deriv(fx_t o);
        fx_t c;
        c = fx_t'(ONE) - o;
        return narrow(fx_mul(o, c));
    endfunction

    function automatic fx_t init_w(int layer, int idx, int j);
        return fx_t'((((5 * idx + 3 * j + 7 * layer) % 9) - 4) * WSCALE);
    endfunction

    function automatic fx_t pat_in(int p, int j);
        return ((p >> j) & 1) != 0 ? fx_t'(ONE) : fx_t'(0);
    endfunction

    function automatic fx_t pat_tgt(int p, int k);
        int ones;
        ones = 0;
        for (int b = 0; b < 16; b++) ones += (p >> b) & 1;
        return ((ones + k) & 1) != 0 ? fx_t'(T_HI) : fx_t'(T_LO);
    endfunction
endpackage

// File: rtl/bpn_seq.sv
module bpn_seq
    import bpn_pkg::*;
#(
    parameter int NUM_IN  = 2,
    parameter int N_HID   = 4,
    parameter int N_OUT   = 2,
    parameter int MAX_FAN = 4,
    parameter int PW      = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [PW-1:0] pat_idx,
    output seq_ctl_t      ctl,
    output logic [PW-1:0] pat_q,
    output logic          busy,
    output logic          done
);
    function automatic int phase_len(phase_e p);
        case (p)
            PH_FWD_IN:  return NUM_IN;
            PH_FWD_HID: return N_HID;
            PH_BACK:    return N_OUT;
            PH_UPD:     return MAX_FAN;
            default:    return 1;
        endcase
    endfunction

    function automatic phase_e phase_next(phase_e p);
        case (p)
            PH_FWD_IN:  return PH_ACT_HID;
            PH_ACT_HID: return PH_FWD_HID;
            PH_FWD_HID: return PH_ACT_OUT;
            PH_ACT_OUT: return PH_ERR_OUT;
            PH_ERR_OUT: return PH_BACK;
            PH_BACK:    return PH_ERR_HID;
            PH_ERR_HID: return PH_UPD;
            PH_UPD:     return PH_DONE;
            default:    return PH_IDLE;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.phase <= PH_IDLE;
            ctl.step  <= '0;
            pat_q     <= '0;
        end else if (ctl.phase == PH_IDLE) begin
            if (start) begin
                ctl.phase <= PH_FWD_IN;
                ctl.step  <= '0;
                pat_q     <= pat_idx;
            end
        end else if (int'(ctl.step) == phase_len(ctl.phase) - 1) begin
            ctl.phase <= phase_next(ctl.phase);
            ctl.step  <= '0;
        end else begin
            ctl.step <= ctl.step + 1'b1;
        end
    end

    assign busy = (ctl.phase != PH_IDLE);
    assign done = (ctl.phase == PH_DONE);
endmodule

// File: rtl/bpn_neuron.sv
module bpn_neuron
    import bpn_pkg::*;
#(
    parameter int LAYER   = 0,
    parameter int IDX     = 0,
    parameter int FAN     = 2,
    parameter int MAX_FAN = 4,
    parameter int LR      = 4096
) (
    input  logic     clk,
    input  logic     rst,
    input  seq_ctl_t ctl,
    input  logic     bus_vld,
    input  fx_t      bus_data,
    input  fx_t [MAX_FAN-1:0] bus_wrow,
    input  fx_t      target,
    output fx_t      out_q,
    output fx_t      delta_q,
    output fx_t [MAX_FAN-1:0] wrow
);
    localparam phase_e FEED_PH = (LAYER == 0) ? PH_FWD_IN  : PH_FWD_HID;
    localparam phase_e ACT_PH  = (LAYER == 0) ? PH_ACT_HID : PH_ACT_OUT;
    localparam fx_t    LR_FX   = fx_t'(LR);

    fx_t  w     [FAN];
    fx_t  inbuf [FAN];
    acc_t acc;

    fx_t        w_sel;
    fx_t        x_sel;
    logic       hit;
    fx_t        net_n;
    logic [7:0] lut_idx;
    fx_t        upd_val;
    fx_t        err_in;

    always_comb begin
        w_sel = '0;
        x_sel = '0;
        hit   = 1'b0;
        for (int j = 0; j < FAN; j++) begin
            if (int'(ctl.step) == j) begin
                w_sel = w[j];
                x_sel = inbuf[j];
                hit   = 1'b1;
            end
        end
        net_n   = narrow(acc);
        lut_idx = net_n[DW-1:DW-8] ^ 8'h80;
        upd_val = sat16(acc_t'(w_sel) +
                        acc_t'(narrow(fx_mul(narrow(fx_mul(x_sel, delta_q)), LR_FX))));
        err_in  = sat16(acc_t'(target) - acc_t'(out_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            out_q   <= '0;
            delta_q <= '0;
            for (int j = 0; j < FAN; j++) begin
                w[j]     <= init_w(LAYER, IDX, j);
                inbuf[j] <= '0;
            end
        end else begin
            case (ctl.phase)
                PH_IDLE: acc <= '0;
                FEED_PH: begin
                    if (bus_vld && hit) begin
                        acc <= acc + fx_mul(bus_data, w_sel);
                        for (int j = 0; j < FAN; j++)
                            if (int'(ctl.step) == j) inbuf[j] <= bus_data;
                    end
                end
                ACT_PH: out_q <= act_lut(lut_idx);
                PH_ERR_OUT: begin
                    if (LAYER == 1) delta_q <= narrow(fx_mul(deriv(out_q), err_in));
                    else            acc     <= '0;
                end
                PH_BACK: begin
                    if (LAYER == 0 && bus_vld)
                        acc <= acc + fx_mul(bus_data, bus_wrow[IDX]);
                end
                PH_ERR_HID: begin
                    if (LAYER == 0) delta_q <= narrow(fx_mul(deriv(out_q), net_n));
                end
                PH_UPD: begin
                    for (int j = 0; j < FAN; j++)
                        if (int'(ctl.step) == j) w[j] <= upd_val;
                end
                default: ;
            endcase
        end
    end

    for (genvar j = 0; j < MAX_FAN; j++) begin : g_row
        if (j < FAN) begin : g_used
            assign wrow[j] = w[j];
        end else begin : g_pad
            assign wrow[j] = '0;
        end
    end
endmodule

// File: rtl/bpn_array.sv
module bpn_array
    import bpn_pkg::*;
#(
    parameter int NUM_IN  = 2,
    parameter int N_HID   = 4,
    parameter int N_OUT   = 2,
    parameter int NUM_PAT = 4,
    parameter int LR      = 4096
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [$clog2(NUM_PAT)-1:0]  pat_idx,
    output logic                        busy,
    output logic                        done,
    output logic [DW*N_OUT-1:0]         y_out,
    output logic [DW*N_OUT-1:0]         err_out
);
    localparam int PW      = $clog2(NUM_PAT);
    localparam int MAX_FAN = (NUM_IN > N_HID) ? NUM_IN : N_HID;
    localparam int NN      = N_HID + N_OUT;

    seq_ctl_t          ctl;
    logic [PW-1:0]     pat_q;
    logic              bus_vld;
    fx_t               bus_data;
    fx_t [MAX_FAN-1:0] bus_wrow;
    fx_t               n_out   [NN];
    fx_t               n_delta [NN];
    fx_t [MAX_FAN-1:0] n_wrow  [NN];

    bpn_seq #(
        .NUM_IN(NUM_IN), .N_HID(N_HID), .N_OUT(N_OUT), .MAX_FAN(MAX_FAN), .PW(PW)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .pat_idx(pat_idx),
        .ctl(ctl), .pat_q(pat_q), .busy(busy), .done(done)
    );

    always_comb begin
        bus_vld  = 1'b0;
        bus_data = '0;
        bus_wrow = '0;
        case (ctl.phase)
            PH_FWD_IN: begin
                for (int j = 0; j < NUM_IN; j++)
                    if (int'(ctl.step) == j) begin
                        bus_vld  = 1'b1;
                        bus_data = pat_in(int'(pat_q), j);
                    end
            end
            PH_FWD_HID: begin
                for (int h = 0; h < N_HID; h++)
                    if (int'(ctl.step) == h) begin
                        bus_vld  = 1'b1;
                        bus_data = n_out[h];
                    end
            end
            PH_BACK: begin
                for (int k = 0; k < N_OUT; k++)
                    if (int'(ctl.step) == k) begin
                        bus_vld  = 1'b1;
                        bus_data = n_delta[N_HID+k];
                        bus_wrow = n_wrow[N_HID+k];
                    end
            end
            default: ;
        endcase
    end

    for (genvar i = 0; i < NN; i++) begin : g_neu
        localparam int LYR = (i < N_HID) ? 0 : 1;
        localparam int LIX = (i < N_HID) ? i : i - N_HID;
        localparam int FN  = (i < N_HID) ? NUM_IN : N_HID;
        fx_t tgt;
        assign tgt = (LYR == 1) ? pat_tgt(int'(pat_q), LIX) : fx_t'(0);
        bpn_neuron #(
            .LAYER(LYR), .IDX(LIX), .FAN(FN), .MAX_FAN(MAX_FAN), .LR(LR)
        ) u_neu (
            .clk(clk), .rst(rst), .ctl(ctl),
            .bus_vld(bus_vld), .bus_data(bus_data), .bus_wrow(bus_wrow),
            .target(tgt),
            .out_q(n_out[i]), .delta_q(n_delta[i]), .wrow(n_wrow[i])
        );
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_pack
        assign y_out[k*DW +: DW]   = n_out[N_HID+k];
        assign err_out[k*DW +: DW] = n_delta[N_HID+k];
    end
endmodule

// File: rtl/bpn_array_chk.sv
module bpn_array_chk #(
    parameter int N_OUT = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic [16*N_OUT-1:0]   y_out
);
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r2_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(y_out));

    for (genvar k = 0; k < N_OUT; k++) begin : g_rng
        a_r7_out_range: assert property (@(posedge clk) disable iff (rst)
            ($signed(y_out[k*16 +: 16]) >= 0) && ($signed(y_out[k*16 +: 16]) <= 4096));
    end
endmodule

bind bpn_array bpn_array_chk #(.N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .y_out(y_out)
);

// File: tb/tb_bpn_array.sv
`timescale 1ns/1ps
module tb_bpn_array;
    localparam real CLK_NS = 8.0;
    localparam int  LAT    = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  pat_idx = '0;
    logic        busy, done;
    logic [31:0] y_out, err_out;

    bpn_array dut (
        .clk(clk), .rst(rst), .start(start), .pat_idx(pat_idx),
        .busy(busy), .done(done), .y_out(y_out), .err_out(err_out)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int y0; int y1; int e0; int e1; int rec; } exp_t;
    exp_t sbq[$];

    int wh [4][2];
    int wo [2][4];
    int last_y0, last_y1;

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clamp16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int nr(int v);
        return clamp16(v >>> 12);
    endfunction

    function automatic int sig(int net);
        int c, a, g;
        c = net >>> 8;
        a = (c < 0) ? -c : c;
        if (a >= 80)      g = 4096;
        else if (a >= 38) g = 3456 + 8 * a;
        else if (a >= 16) g = 2560 + 32 * a;
        else              g = 2048 + 64 * a;
        return (net >= 0) ? g : 4096 - g;
    endfunction

    function automatic int slope(int o);
        return nr(o * (4096 - o));
    endfunction

    task automatic model_init();
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 2; j++) wh[i][j] = ((5*i + 3*j) % 9 - 4) * 512;
        for (int k = 0; k < 2; k++)
            for (int j = 0; j < 4; j++) wo[k][j] = ((5*k + 3*j + 7) % 9 - 4) * 512;
    endtask

    task automatic model_pass(int p, output exp_t e);
        int x[2]; int h[4]; int y[2]; int t[2]; int eo[2]; int eh[4];
        int s, ones;
        ones = (p & 1) + ((p >> 1) & 1);
        for (int j = 0; j < 2; j++) x[j] = ((p >> j) & 1) ? 4096 : 0;
        for (int k = 0; k < 2; k++) t[k] = ((ones + k) % 2 == 1) ? 3686 : 410;
        for (int i = 0; i < 4; i++) begin
            s = 0;
            for (int j = 0; j < 2; j++) s += x[j] * wh[i][j];
            h[i] = sig(nr(s));
        end
        for (int k = 0; k < 2; k++) begin
            s = 0;
            for (int j = 0; j < 4; j++) s += h[j] * wo[k][j];
            y[k] = sig(nr(s));
            eo[k] = nr(slope(y[k]) * clamp16(t[k] - y[k]));
        end
        for (int i = 0; i < 4; i++) begin
            s = 0;
            for (int k = 0; k < 2; k++) s += eo[k] * wo[k][i];
            eh[i] = nr(slope(h[i]) * nr(s));
        end
        for (int k = 0; k < 2; k++)
            for (int j = 0; j < 4; j++)
                wo[k][j] = clamp16(wo[k][j] + nr(nr(h[j] * eo[k]) * 4096));
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 2; j++)
                wh[i][j] = clamp16(wh[i][j] + nr(nr(x[j] * eh[i]) * 4096));
        e.y0 = y[0]; e.y1 = y[1]; e.e0 = eo[0]; e.e1 = eo[1]; e.rec = 0;
    endtask

    // Monitor: pops expected results at each done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R4 unexpected extra done", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(cyc - e.rec == LAT, "R3 done latency", cyc - e.rec, LAT);
                check($signed(y_out[15:0]) == e.y0, "R5 R6 R7 R9 R10 R11 y0",
                      $signed(y_out[15:0]), e.y0);
                check($signed(y_out[31:16]) == e.y1, "R5 R6 R7 R9 R10 R11 y1",
                      $signed(y_out[31:16]), e.y1);
                check($signed(err_out[15:0]) == e.e0, "R8 err0",
                      $signed(err_out[15:0]), e.e0);
                check($signed(err_out[31:16]) == e.e1, "R8 err1",
                      $signed(err_out[31:16]), e.e1);
            end
        end
    end

    // Driver: issues a pass and pushes its expected outcome
    task automatic run_pass(int p, bit poke);
        exp_t e;
        @(negedge clk);
        start = 1'b1;
        pat_idx = p[1:0];
        model_pass(p, e);
        @(negedge clk);
        start = 1'b0;
        e.rec = cyc;
        sbq.push_back(e);
        last_y0 = e.y0;
        last_y1 = e.y1;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            pat_idx = 2'(p + 1);
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R4 idle after pass", int'(busy), 0);
        check($signed(y_out[15:0]) == last_y0, "R12 y0 held", $signed(y_out[15:0]), last_y0);
        check($signed(y_out[31:16]) == last_y1, "R12 y1 held", $signed(y_out[31:16]), last_y1);
    endtask

    initial begin
        #(CLK_NS * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_init();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        check(done == 1'b0, "R1 done reset", int'(done), 0);
        check(y_out == 32'd0, "R1 y_out reset", int'(y_out), 0);
        check(err_out == 32'd0, "R1 err_out reset", int'(err_out), 0);

        run_pass(0, 1'b0);
        run_pass(1, 1'b0);
        run_pass(2, 1'b1);
        run_pass(3, 1'b0);
        run_pass(3, 1'b0);
        for (int r = 0; r < 3; r++)
            for (int p = 0; p < 4; p++) run_pass(p, 1'b0);

        check(sbq.size() == 0, "R3 all passes completed", sbq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule